// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block is the hazard controller for an in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. Each cycle the surrounding pipeline gives it a hazard descriptor for the instruction in decode. The descriptor holds the source and destination register numbers, a write-enable, a load flag and an immediate flag. The pipeline also gives it the destination, write-enable and valid bit of the instructions in memory and writeback. The block keeps its own copy of the execute-stage descriptor. It loads that copy from decode on every clock edge, or with an empty slot when it stalls.

From these inputs the block drives the select codes of the two ALU operand multiplexers. An operand can take the register-file value, the memory-stage ALU result, the writeback-stage result or, for the second operand only, the immediate.

A load whose destination is read by the very next instruction cannot be covered by forwarding. In that case the block raises a front-end stall for one cycle. While the stall is high, the program counter and the fetch/decode register keep their contents. On the same edge an empty slot, with its write-enable cleared, enters execute. The dependent instruction then moves into execute one cycle later and takes the load data from the writeback path.

Top module: `fwd_interlock_top`

## Requirements
- R1: When the execute-stage instruction has its immediate flag set, `selOpB` is 3 (immediate), whatever the bypass comparisons find.
- R2: Otherwise, if execute source B equals `memDst`, `selOpB` is 1 (memory result). This holds even when `wbDst` also matches.
- R3: Otherwise, if execute source B equals `wbDst`, `selOpB` is 2 (writeback result). If neither stage matches, `selOpB` is 0 (register file).
- R4: `selOpA` follows the same memory-before-writeback priority and uses the codes 0, 1 and 2. It is never 3.
- R5: Register 0 is never forwarded and never causes a stall.
- R6: A producing stage counts as a match only when its write-enable and its valid bit are both set.
- R7: `stallFront` is high in the same cycle that a valid load with a write-enable sits in execute and the valid decode instruction reads the load's destination as source A or as source B.
- R8: After a stall, the next cycle has an empty execute slot (`exBubble` = 1) and no new stall. The held instruction then enters execute and forwards the load data from writeback (code 2).
- R9: After reset, `exBubble` is 1, `stallFront` is 0 and both select codes are 0.
- R10: A non-load producer in execute never causes a stall, even when its destination matches a decode source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode slot holds a real instruction |
| decSrcA | input | REG_W | Decode source register A |
| decSrcB | input | REG_W | Decode source register B |
| decDst | input | REG_W | Decode destination register |
| decWrEn | input | 1 | Decode instruction writes a register |
| decIsLoad | input | 1 | Decode instruction is a load |
| decUseImm | input | 1 | Decode instruction takes an immediate as operand B |
| memDst | input | REG_W | Memory-stage destination register |
| memWrEn | input | 1 | Memory-stage write-enable |
| memValid | input | 1 | Memory stage holds a real instruction |
| wbDst | input | REG_W | Writeback-stage destination register |
| wbWrEn | input | 1 | Writeback-stage write-enable |
| wbValid | input | 1 | Writeback stage holds a real instruction |
| selOpA | output | 2 | Operand A select: 0 register file, 1 memory, 2 writeback |
| selOpB | output | 2 | Operand B select: 0 register file, 1 memory, 2 writeback, 3 immediate |
| stallFront | output | 1 | Hold the PC and fetch/decode register, and send an empty slot into execute |
| exBubble | output | 1 | The execute slot is empty |

## Verification
The bench puts the same register number in memory and writeback at once. A design with the priority reversed would forward stale writeback data. It sets the immediate flag while a bypass matches. A design that tests the bypass first would steer a register value into an immediate slot. It offers matches on register 0 and from stages whose write-enable or valid bit is low. A loose comparator would forward garbage there. It runs the load-use sequence on both source fields and follows it through the empty slot. A missing or doubled bubble, or a stall on a non-load producer, shows up as a wrong `stallFront` or `exBubble` or as a wrong select code when the held instruction reaches execute.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_MEM = 2'd1,
    SEL_WB  = 2'd2,
    SEL_IMM = 2'd3
  } opSel_e;

  // Comparator results, datapath -> control
  typedef struct packed {
    logic [1:0] memHit;   // index 0 = operand A, 1 = operand B
    logic [1:0] wbHit;
    logic       loadHit;
    logic       useImm;
    logic       exValid;
  } hitInfo_t;

  // Strobes, control -> datapath
  typedef struct packed {
    logic insertBubble;
  } ctrlStrobe_t;

endpackage

// File: rtl/hazard_datapath.sv
module hazard_datapath
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decValid,
  input  logic [REG_W-1:0] decSrcA,
  input  logic [REG_W-1:0] decSrcB,
  input  logic [REG_W-1:0] decDst,
  input  logic             decWrEn,
  input  logic             decIsLoad,
  input  logic             decUseImm,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWrEn,
  input  logic             memValid,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbWrEn,
  input  logic             wbValid,
  input  ctrlStrobe_t      strobe,
  output hitInfo_t         hits
);

  localparam int NUM_SRC = 2;

  // Execute-stage hazard descriptor
  logic             exValid;
  logic [REG_W-1:0] exSrc [NUM_SRC];
  logic [REG_W-1:0] exDst;
  logic             exWrEn;
  logic             exIsLoad;
  logic             exUseImm;

  logic [REG_W-1:0] decSrc [NUM_SRC];
  assign decSrc[0] = decSrcA;
  assign decSrc[1] = decSrcB;

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.insertBubble || !decValid) begin
      exValid  <= 1'b0;
      exDst    <= '0;
      exWrEn   <= 1'b0;
      exIsLoad <= 1'b0;
      exUseImm <= 1'b0;
      for (int i = 0; i < NUM_SRC; i++) exSrc[i] <= '0;
    end else begin
      exValid  <= 1'b1;
      exDst    <= decDst;
      exWrEn   <= decWrEn;
      exIsLoad <= decIsLoad;
      exUseImm <= decUseImm;
      for (int i = 0; i < NUM_SRC; i++) exSrc[i] <= decSrc[i];
    end
  end

  logic memLive, wbLive, loadLive;
  assign memLive  = memValid && memWrEn && (memDst != '0);
  assign wbLive   = wbValid && wbWrEn && (wbDst != '0);
  assign loadLive = exValid && exIsLoad && exWrEn && (exDst != '0);

  logic [NUM_SRC-1:0] memHitV, wbHitV, useHitV;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
      assign memHitV[s] = memLive && (memDst == exSrc[s]);
      assign wbHitV[s]  = wbLive  && (wbDst  == exSrc[s]);
      assign useHitV[s] = loadLive && (decSrc[s] == exDst);
    end
  endgenerate

  assign hits.memHit  = memHitV;
  assign hits.wbHit   = wbHitV;
  assign hits.loadHit = decValid && (|useHitV);
  assign hits.useImm  = exUseImm;
  assign hits.exValid = exValid;

endmodule

// File: rtl/hazard_control.sv
module hazard_control
  import hazard_pkg::*;
(
  input  hitInfo_t    hits,
  output opSel_e      selA,
  output opSel_e      selB,
  output ctrlStrobe_t strobe,
  output logic        stallFront,
  output logic        exBubble
);

  always_comb begin
    if (hits.memHit[0])     selA = SEL_MEM;
    else if (hits.wbHit[0]) selA = SEL_WB;
    else                    selA = SEL_RF;
  end

  always_comb begin
    if (hits.useImm)        selB = SEL_IMM;
    else if (hits.memHit[1]) selB = SEL_MEM;
    else if (hits.wbHit[1])  selB = SEL_WB;
    else                     selB = SEL_RF;
  end

  assign stallFront          = hits.loadHit;
  assign strobe.insertBubble = hits.loadHit;
  assign exBubble            = !hits.exValid;

endmodule

// File: rtl/fwd_interlock_top.sv
module fwd_interlock_top
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decValid,
  input  logic [REG_W-1:0] decSrcA,
  input  logic [REG_W-1:0] decSrcB,
  input  logic [REG_W-1:0] decDst,
  input  logic             decWrEn,
  input  logic             decIsLoad,
  input  logic             decUseImm,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWrEn,
  input  logic             memValid,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbWrEn,
  input  logic             wbValid,
  output logic [1:0]       selOpA,
  output logic [1:0]       selOpB,
  output logic             stallFront,
  output logic             exBubble
);

  hitInfo_t    hits;
  ctrlStrobe_t strobe;
  opSel_e      selA, selB;

  hazard_datapath #(.REG_W(REG_W)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .decValid(decValid), .decSrcA(decSrcA), .decSrcB(decSrcB),
    .decDst(decDst), .decWrEn(decWrEn), .decIsLoad(decIsLoad),
    .decUseImm(decUseImm),
    .memDst(memDst), .memWrEn(memWrEn), .memValid(memValid),
    .wbDst(wbDst), .wbWrEn(wbWrEn), .wbValid(wbValid),
    .strobe(strobe), .hits(hits)
  );

  hazard_control ctl_i (
    .hits(hits), .selA(selA), .selB(selB), .strobe(strobe),
    .stallFront(stallFront), .exBubble(exBubble)
  );

  assign selOpA = selA;
  assign selOpB = selB;

endmodule

// File: rtl/fwd_interlock_chk.sv
module fwd_interlock_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             decValid,
  input logic [REG_W-1:0] memDst,
  input logic             memWrEn,
  input logic             memValid,
  input logic [REG_W-1:0] wbDst,
  input logic             wbWrEn,
  input logic             wbValid,
  input logic [1:0]       selOpA,
  input logic [1:0]       selOpB,
  input logic             stallFront,
  input logic             exBubble
);

  p_opa_never_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    selOpA != 2'd3);

  p_stall_gives_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stallFront |=> exBubble);

  p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stallFront |=> !stallFront);

  p_mem_fwd_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (selOpA == 2'd1 || selOpB == 2'd1) |-> (memWrEn && memValid));

  p_wb_fwd_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (selOpA == 2'd2 || selOpB == 2'd2) |-> (wbWrEn && wbValid));

  p_no_zero_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((selOpA == 2'd1 || selOpB == 2'd1) |-> memDst != '0) and
    ((selOpA == 2'd2 || selOpB == 2'd2) |-> wbDst != '0));

  p_stall_needs_decode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stallFront |-> decValid);

  p_stall_not_on_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exBubble |-> !stallFront);

endmodule

bind fwd_interlock_top fwd_interlock_chk #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .decValid(decValid),
  .memDst(memDst), .memWrEn(memWrEn), .memValid(memValid),
  .wbDst(wbDst), .wbWrEn(wbWrEn), .wbValid(wbValid),
  .selOpA(selOpA), .selOpB(selOpB),
  .stallFront(stallFront), .exBubble(exBubble)
);

// File: tb/fwd_interlock_top_tb_top.sv
`timescale 1ns/1ps
module fwd_interlock_top_tb_top;

  localparam int REG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             decValid, decWrEn, decIsLoad, decUseImm;
  logic [REG_W-1:0] decSrcA, decSrcB, decDst;
  logic [REG_W-1:0] memDst, wbDst;
  logic             memWrEn, memValid, wbWrEn, wbValid;
  logic [1:0]       selOpA, selOpB;
  logic             stallFront, exBubble;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  fwd_interlock_top #(.REG_W(REG_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .decValid(decValid), .decSrcA(decSrcA), .decSrcB(decSrcB),
    .decDst(decDst), .decWrEn(decWrEn), .decIsLoad(decIsLoad),
    .decUseImm(decUseImm),
    .memDst(memDst), .memWrEn(memWrEn), .memValid(memValid),
    .wbDst(wbDst), .wbWrEn(wbWrEn), .wbValid(wbValid),
    .selOpA(selOpA), .selOpB(selOpB),
    .stallFront(stallFront), .exBubble(exBubble)
  );

  task automatic chk(input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic decIdle();
    decValid = 0; decSrcA = '0; decSrcB = '0; decDst = '0;
    decWrEn = 0; decIsLoad = 0; decUseImm = 0;
  endtask

  task automatic setDec(input int a, input int b, input int d,
                        input bit we, input bit ld, input bit imm);
    decValid = 1; decSrcA = REG_W'(a); decSrcB = REG_W'(b); decDst = REG_W'(d);
    decWrEn = we; decIsLoad = ld; decUseImm = imm;
  endtask

  task automatic setMem(input int d, input bit we, input bit v);
    memDst = REG_W'(d); memWrEn = we; memValid = v;
  endtask

  task automatic setWb(input int d, input bit we, input bit v);
    wbDst = REG_W'(d); wbWrEn = we; wbValid = v;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Put one instruction into execute, leave decode empty, clear mem/wb
  task automatic intoEx(input int a, input int b, input int d,
                        input bit we, input bit ld, input bit imm);
    setDec(a, b, d, we, ld, imm);
    cycle();
    decIdle();
    setMem(0, 0, 0);
    setWb(0, 0, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R9 exBubble", exBubble, 1);
    chk("R9 stallFront", stallFront, 0);
    chk("R9 selOpA", selOpA, 0);
    chk("R9 selOpB", selOpB, 0);
  endtask

  task automatic t_basic_fwd();
    intoEx(3, 4, 9, 1, 0, 0);
    setMem(3, 1, 1); setWb(4, 1, 1); #1;
    chk("R4 selOpA mem", selOpA, 1);
    chk("R3 selOpB wb", selOpB, 2);
    setMem(4, 1, 1); setWb(3, 1, 1); #1;
    chk("R4 selOpA wb", selOpA, 2);
    chk("R2 selOpB mem", selOpB, 1);
    setMem(12, 1, 1); setWb(13, 1, 1); #1;
    chk("R3 selOpB rf", selOpB, 0);
    chk("R4 selOpA rf", selOpA, 0);
  endtask

  task automatic t_priority();
    intoEx(5, 5, 9, 1, 0, 0);
    setMem(5, 1, 1); setWb(5, 1, 1); #1;
    chk("R2 selOpB mem over wb", selOpB, 1);
    chk("R4 selOpA mem over wb", selOpA, 1);
  endtask

  task automatic t_imm();
    intoEx(6, 6, 9, 1, 0, 1);
    setMem(6, 1, 1); setWb(0, 0, 0); #1;
    chk("R1 selOpB imm over mem", selOpB, 3);
    chk("R4 selOpA still mem", selOpA, 1);
    setMem(0, 0, 0); setWb(6, 1, 1); #1;
    chk("R1 selOpB imm over wb", selOpB, 3);
    chk("R4 selOpA wb", selOpA, 2);
  endtask

  task automatic t_zero();
    intoEx(0, 0, 9, 1, 0, 0);
    setMem(0, 1, 1); setWb(0, 1, 1); #1;
    chk("R5 selOpA r0", selOpA, 0);
    chk("R5 selOpB r0", selOpB, 0);
    // load to r0 with dependent reading r0
    intoEx(1, 2, 0, 1, 1, 0);
    setDec(0, 0, 8, 1, 0, 0); #1;
    chk("R5 no stall r0", stallFront, 0);
    cycle(); decIdle();
  endtask

  task automatic t_gating();
    intoEx(7, 8, 9, 1, 0, 0);
    setMem(7, 0, 1); setWb(8, 1, 0); #1;
    chk("R6 mem we low", selOpA, 0);
    chk("R6 wb invalid", selOpB, 0);
    setMem(8, 1, 0); setWb(7, 0, 1); #1;
    chk("R6 mem invalid", selOpB, 0);
    chk("R6 wb we low", selOpA, 0);
  endtask

  task automatic t_load_use_b();
    intoEx(1, 2, 7, 1, 1, 0);        // load r7 in execute
    setDec(2, 7, 10, 1, 0, 0); #1;   // consumer reads r7 as B
    chk("R7 stall on B", stallFront, 1);
    cycle();                         // load -> mem, bubble -> ex
    setMem(7, 1, 1); #1;
    chk("R8 bubble", exBubble, 1);
    chk("R8 no second stall", stallFront, 0);
    cycle();                         // consumer -> ex, load -> wb
    decIdle(); setMem(0, 0, 0); setWb(7, 1, 1); #1;
    chk("R8 consumer in ex", exBubble, 0);
    chk("R8 fwd from wb", selOpB, 2);
    chk("R8 selOpA rf", selOpA, 0);
  endtask

  task automatic t_load_use_a();
    intoEx(3, 4, 6, 1, 1, 0);
    setDec(6, 1, 10, 1, 0, 1); #1;
    chk("R7 stall on A", stallFront, 1);
    decValid = 0; #1;
    chk("R7 no stall invalid decode", stallFront, 0);
    setDec(11, 12, 10, 1, 0, 0); #1;
    chk("R7 no stall unrelated", stallFront, 0);
    cycle(); decIdle();
  endtask

  task automatic t_non_load();
    intoEx(1, 2, 7, 1, 0, 0);
    setDec(7, 7, 10, 1, 0, 0); #1;
    chk("R10 alu producer", stallFront, 0);
    cycle(); decIdle(); #1;
    chk("R10 no bubble", exBubble, 0);
  endtask

  initial begin
    rst_n = 0;
    decIdle(); setMem(0, 0, 0); setWb(0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic_fwd();
    t_priority();
    t_imm();
    t_zero();
    t_gating();
    t_load_use_b();
    t_load_use_a();
    t_non_load();
    cycle();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule